// File: doc/BRIEF.md
# Linked-List Descriptor DMA Engine

This block moves a data transfer between a word-wide system memory and the data stream of an SD card interface. Each piece of the transfer is described by a 16-byte descriptor in memory. The descriptors form a singly linked list. After a start pulse the engine fetches a descriptor and works out how many bytes it covers. It then streams that many bytes through a one-word holding register, in the direction that `is_write_i` selects. It writes the descriptor's status word back with the ownership bit cleared, and then follows the next pointer. It stops after a descriptor flagged as last, or when the programmed byte count is used up, whichever comes first.

When it finishes, the engine raises a one-cycle done strobe together with bit vectors. The surrounding controller ORs these vectors into its raw interrupt register and its DMA status register. The largest size one descriptor may cover is a build parameter, normally 8 KiB or 64 KiB. Card-side signalling, CRC and register decoding belong to neighbouring blocks.

Top module: `sd_desc_dma`

## Requirements
- R1: A descriptor is four consecutive 32-bit words, fetched in the order status (offset 0), size (offset 4), buffer address (offset 8), next-descriptor address (offset 12). The low two bits of descriptor addresses are ignored.
- R2: A size field of zero, or a size above MAX_DESC_BYTES, is replaced by MAX_DESC_BYTES.
- R3: A descriptor moves min(effective size, remaining count) bytes, rounded up to whole words. Its buffer address has bits 1:0 forced to zero, so every memory access is word aligned.
- R4: With is_write_i=1, buffer words are read from memory in ascending address order and presented on the card write stream in that order. With is_write_i=0, card read-stream words are stored to ascending buffer addresses.
- R5: After its data has moved, each descriptor's status word is written back to the descriptor address with bit 31 (hold) cleared and every other bit kept.
- R6: The engine fetches the next descriptor from the next-address word only when status bit 2 (last) is clear and the remaining count is non-zero.
- R7: A start is refused when the byte count is 0, the block size is 0, dma_en_i is low, or a read is requested while card_rdy_i is low. A refused start makes no memory access and no completion strobe, and the engine stays idle.
- R8: Completion gives a one-cycle done_o with raw_set_o bits 3 and 16 set. It also sets dma_set_o bit 8, plus bit 0 for a write or bit 1 for a read.
- R9: remain_o is loaded with the byte count on an accepted start. It drops by each finished descriptor's byte amount and saturates at zero.
- R10: An error response on a buffer access ends that descriptor early. Its write-back status also has bit 30 set. No further descriptor is fetched, remain_o is not reduced, and completion is still signalled.
- R11: A memory request keeps its address, direction and write data stable until it is acknowledged. Each acknowledge completes exactly one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| dma_en_i | input | 1 | DMA enable from global control |
| is_write_i | input | 1 | 1: memory to card, 0: card to memory |
| byte_count_i | input | CNT_W | Total bytes to move |
| block_size_i | input | CNT_W | Card block size (only checked for zero) |
| desc_base_i | input | 32 | Address of the first descriptor |
| card_rdy_i | input | 1 | Card has read data ready |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 32 | Memory byte address (word aligned) |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | 32 | Memory read data, valid with ack |
| mem_err_i | input | 1 | Memory error, valid with ack |
| cw_valid_o | output | 1 | Card write stream valid |
| cw_data_o | output | 32 | Card write stream data |
| cw_ready_i | input | 1 | Card write stream ready |
| cr_valid_i | input | 1 | Card read stream valid |
| cr_data_i | input | 32 | Card read stream data |
| cr_ready_o | output | 1 | Card read stream ready |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion strobe |
| remain_o | output | CNT_W | Remaining byte count |
| raw_set_o | output | 32 | Raw interrupt bits to set, valid with done_o |
| dma_set_o | output | 32 | DMA status bits to set, valid with done_o |

## Verification
The bench builds the engine with MAX_DESC_BYTES set to 32, while CNT_W keeps its default. A zero or oversized size field therefore clamps to eight words, and both clamp paths can be checked against a small memory model in a few hundred cycles. With this small limit, a single byte count can also span several descriptors. That brings within reach the stop on the last flag with bytes still remaining, and the stop when the count runs out with no last flag set. The memory model can return an error at a chosen address, which exercises the early end and the error bit in the written-back descriptor.

// File: rtl/sd_desc_dma_pkg.sv
package sd_desc_dma_pkg;

    localparam int WORD_W = 32;

    // descriptor status word bits
    localparam int ST_HOLD = 31;
    localparam int ST_ERR  = 30;
    localparam int ST_LAST = 2;

    // completion bit positions decoded by the neighbouring status registers
    localparam int RAW_DATA_DONE = 3;
    localparam int RAW_AUX       = 16;
    localparam int DMA_SUMMARY   = 8;
    localparam int DMA_TX        = 0;
    localparam int DMA_RX        = 1;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_FETCH,
        PH_SETUP,
        PH_MEMRD,
        PH_CARDW,
        PH_CARDR,
        PH_MEMWR,
        PH_WBACK,
        PH_FINISH
    } phase_t;

endpackage

// File: rtl/sd_desc_dma_sizer.sv
module sd_desc_dma_sizer #(
    parameter int MAX_DESC_BYTES = 65536,
    parameter int CNT_W          = 32,
    parameter int SIZE_W         = $clog2(MAX_DESC_BYTES) + 1
) (
    input  logic [31:0]       size_i,
    input  logic [CNT_W-1:0]  remain_i,
    output logic [SIZE_W-1:0] bytes_o,
    output logic [SIZE_W-1:0] words_o
);

    logic [SIZE_W-1:0] eff;
    logic [SIZE_W:0]   rounded;

    always_comb begin
        if (size_i == 32'd0 || size_i > 32'(MAX_DESC_BYTES))
            eff = SIZE_W'(MAX_DESC_BYTES);
        else
            eff = size_i[SIZE_W-1:0];

        if (remain_i < CNT_W'(eff))
            bytes_o = remain_i[SIZE_W-1:0];
        else
            bytes_o = eff;

        rounded = {1'b0, bytes_o} + (SIZE_W+1)'(3);
        words_o = {1'b0, rounded[SIZE_W:2]};
    end

endmodule

// File: rtl/sd_desc_dma_flags.sv
module sd_desc_dma_flags
    import sd_desc_dma_pkg::*;
(
    input  logic              fire_i,
    input  logic              wr_i,
    output logic [WORD_W-1:0] raw_o,
    output logic [WORD_W-1:0] dma_o
);

    always_comb begin
        raw_o = '0;
        dma_o = '0;
        if (fire_i) begin
            raw_o[RAW_DATA_DONE] = 1'b1;
            raw_o[RAW_AUX]       = 1'b1;
            dma_o[DMA_SUMMARY]   = 1'b1;
            if (wr_i) dma_o[DMA_TX] = 1'b1;
            else      dma_o[DMA_RX] = 1'b1;
        end
    end

endmodule

// File: rtl/sd_desc_dma.sv
module sd_desc_dma
    import sd_desc_dma_pkg::*;
#(
    parameter int MAX_DESC_BYTES = 65536,
    parameter int CNT_W          = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             dma_en_i,
    input  logic             is_write_i,
    input  logic [CNT_W-1:0] byte_count_i,
    input  logic [CNT_W-1:0] block_size_i,
    input  logic [31:0]      desc_base_i,
    input  logic             card_rdy_i,
    output logic             mem_req_o,
    output logic             mem_we_o,
    output logic [31:0]      mem_addr_o,
    output logic [31:0]      mem_wdata_o,
    input  logic             mem_ack_i,
    input  logic [31:0]      mem_rdata_i,
    input  logic             mem_err_i,
    output logic             cw_valid_o,
    output logic [31:0]      cw_data_o,
    input  logic             cw_ready_i,
    input  logic             cr_valid_i,
    input  logic [31:0]      cr_data_i,
    output logic             cr_ready_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [CNT_W-1:0] remain_o,
    output logic [31:0]      raw_set_o,
    output logic [31:0]      dma_set_o
);

    localparam int SIZE_W = $clog2(MAX_DESC_BYTES) + 1;
    localparam logic [31:0] WORD_MASK = ~32'd3;

    typedef struct packed {
        phase_t              ph;
        logic                wr;
        logic [1:0]          widx;
        logic [31:0]         daddr;
        logic [31:0]         dstat;
        logic [31:0]         dsize;
        logic [31:0]         dbuf;
        logic [31:0]         dnext;
        logic [CNT_W-1:0]    remain;
        logic [SIZE_W-1:0]   chunk;
        logic [SIZE_W-1:0]   words;
        logic [31:0]         bptr;
        logic [31:0]         data;
        logic                err;
    } regs_t;

    regs_t r_q, r_d;

    logic [SIZE_W-1:0] sz_bytes, sz_words;
    logic [CNT_W-1:0]  rem_next;
    logic              start_ok;
    logic [31:0]       wb_word;

    sd_desc_dma_sizer #(
        .MAX_DESC_BYTES (MAX_DESC_BYTES),
        .CNT_W          (CNT_W),
        .SIZE_W         (SIZE_W)
    ) u_sizer (
        .size_i   (r_q.dsize),
        .remain_i (r_q.remain),
        .bytes_o  (sz_bytes),
        .words_o  (sz_words)
    );

    sd_desc_dma_flags u_flags (
        .fire_i (r_q.ph == PH_FINISH),
        .wr_i   (r_q.wr),
        .raw_o  (raw_set_o),
        .dma_o  (dma_set_o)
    );

    always_comb begin
        start_ok = dma_en_i && (byte_count_i != '0) && (block_size_i != '0)
                   && (is_write_i || card_rdy_i);

        if (r_q.remain > CNT_W'(r_q.chunk))
            rem_next = r_q.remain - CNT_W'(r_q.chunk);
        else
            rem_next = '0;

        wb_word          = r_q.dstat;
        wb_word[ST_HOLD] = 1'b0;
        if (r_q.err) wb_word[ST_ERR] = 1'b1;

        r_d = r_q;
        unique case (r_q.ph)
            PH_IDLE: begin
                if (start_i && start_ok) begin
                    r_d.ph     = PH_FETCH;
                    r_d.wr     = is_write_i;
                    r_d.remain = byte_count_i;
                    r_d.daddr  = desc_base_i & WORD_MASK;
                    r_d.widx   = 2'd0;
                    r_d.err    = 1'b0;
                end
            end
            PH_FETCH: begin
                if (mem_ack_i) begin
                    unique case (r_q.widx)
                        2'd0: r_d.dstat = mem_rdata_i;
                        2'd1: r_d.dsize = mem_rdata_i;
                        2'd2: r_d.dbuf  = mem_rdata_i;
                        default: r_d.dnext = mem_rdata_i;
                    endcase
                    r_d.widx = r_q.widx + 2'd1;
                    if (mem_err_i)
                        r_d.ph = PH_FINISH;
                    else if (r_q.widx == 2'd3)
                        r_d.ph = PH_SETUP;
                end
            end
            PH_SETUP: begin
                r_d.chunk = sz_bytes;
                r_d.words = sz_words;
                r_d.bptr  = r_q.dbuf & WORD_MASK;
                if (sz_words == '0)
                    r_d.ph = PH_WBACK;
                else
                    r_d.ph = r_q.wr ? PH_MEMRD : PH_CARDR;
            end
            PH_MEMRD: begin
                if (mem_ack_i) begin
                    if (mem_err_i) begin
                        r_d.err = 1'b1;
                        r_d.ph  = PH_WBACK;
                    end else begin
                        r_d.data = mem_rdata_i;
                        r_d.ph   = PH_CARDW;
                    end
                end
            end
            PH_CARDW: begin
                if (cw_ready_i) begin
                    r_d.bptr  = r_q.bptr + 32'd4;
                    r_d.words = r_q.words - SIZE_W'(1);
                    r_d.ph    = (r_q.words == SIZE_W'(1)) ? PH_WBACK : PH_MEMRD;
                end
            end
            PH_CARDR: begin
                if (cr_valid_i) begin
                    r_d.data = cr_data_i;
                    r_d.ph   = PH_MEMWR;
                end
            end
            PH_MEMWR: begin
                if (mem_ack_i) begin
                    if (mem_err_i) begin
                        r_d.err = 1'b1;
                        r_d.ph  = PH_WBACK;
                    end else begin
                        r_d.bptr  = r_q.bptr + 32'd4;
                        r_d.words = r_q.words - SIZE_W'(1);
                        r_d.ph    = (r_q.words == SIZE_W'(1)) ? PH_WBACK : PH_CARDR;
                    end
                end
            end
            PH_WBACK: begin
                if (mem_ack_i) begin
                    if (r_q.err || mem_err_i) begin
                        r_d.ph = PH_FINISH;
                    end else begin
                        r_d.remain = rem_next;
                        if (r_q.dstat[ST_LAST] || rem_next == '0) begin
                            r_d.ph = PH_FINISH;
                        end else begin
                            r_d.daddr = r_q.dnext & WORD_MASK;
                            r_d.widx  = 2'd0;
                            r_d.ph    = PH_FETCH;
                        end
                    end
                end
            end
            PH_FINISH: r_d.ph = PH_IDLE;
            default:   r_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        unique case (r_q.ph)
            PH_FETCH: begin
                mem_req_o  = 1'b1;
                mem_addr_o = r_q.daddr + {28'd0, r_q.widx, 2'b00};
            end
            PH_MEMRD: begin
                mem_req_o  = 1'b1;
                mem_addr_o = r_q.bptr;
            end
            PH_MEMWR: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = r_q.bptr;
                mem_wdata_o = r_q.data;
            end
            PH_WBACK: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = r_q.daddr;
                mem_wdata_o = wb_word;
            end
            default: ;
        endcase
        cw_valid_o = (r_q.ph == PH_CARDW);
        cw_data_o  = r_q.data;
        cr_ready_o = (r_q.ph == PH_CARDR);
        busy_o     = (r_q.ph != PH_IDLE);
        done_o     = (r_q.ph == PH_FINISH);
        remain_o   = r_q.remain;
    end

endmodule

// File: rtl/sd_desc_dma_chk.sv
module sd_desc_dma_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mem_req_o,
    input logic             mem_we_o,
    input logic [31:0]      mem_addr_o,
    input logic [31:0]      mem_wdata_o,
    input logic             mem_ack_i,
    input logic             cw_valid_o,
    input logic [31:0]      cw_data_o,
    input logic             cw_ready_i,
    input logic             busy_o,
    input logic             done_o,
    input logic [CNT_W-1:0] remain_o,
    input logic [31:0]      dma_set_o
);

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)
                                    && $stable(mem_we_o) && $stable(mem_wdata_o));

    // R3
    word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> mem_addr_o[1:0] == 2'b00);

    // R4
    card_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cw_valid_o && !cw_ready_i |=> cw_valid_o && $stable(cw_data_o));

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mem_req_o && !cw_valid_o);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    done_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $countones(dma_set_o[1:0]) == 1);

    // R9
    remain_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && $past(busy_o) |-> remain_o <= $past(remain_o));

endmodule

bind sd_desc_dma sd_desc_dma_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ack_i   (mem_ack_i),
    .cw_valid_o  (cw_valid_o),
    .cw_data_o   (cw_data_o),
    .cw_ready_i  (cw_ready_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .remain_o    (remain_o),
    .dma_set_o   (dma_set_o)
);

// File: tb/sd_desc_dma_tb_top.sv
module sd_desc_dma_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int MAXB       = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, dma_en_i = 1'b0, is_write_i = 1'b1, card_rdy_i = 1'b0;
    logic [31:0] byte_count_i = '0, block_size_i = '0, desc_base_i = '0;
    logic        mem_req_o, mem_we_o, mem_ack_i, mem_err_i;
    logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
    logic        cw_valid_o, cw_ready_i, cr_valid_i, cr_ready_o;
    logic [31:0] cw_data_o, cr_data_i;
    logic        busy_o, done_o;
    logic [31:0] remain_o, raw_set_o, dma_set_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    sd_desc_dma #(.MAX_DESC_BYTES(MAXB), .CNT_W(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dma_en_i(dma_en_i),
        .is_write_i(is_write_i), .byte_count_i(byte_count_i),
        .block_size_i(block_size_i), .desc_base_i(desc_base_i),
        .card_rdy_i(card_rdy_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
        .mem_rdata_i(mem_rdata_i), .mem_err_i(mem_err_i), .cw_valid_o(cw_valid_o),
        .cw_data_o(cw_data_o), .cw_ready_i(cw_ready_i), .cr_valid_i(cr_valid_i),
        .cr_data_i(cr_data_i), .cr_ready_o(cr_ready_o), .busy_o(busy_o),
        .done_o(done_o), .remain_o(remain_o), .raw_set_o(raw_set_o),
        .dma_set_o(dma_set_o)
    );

    // memory model with error injection and a bench poke port
    logic [31:0] mem [0:255];
    logic        pk_en = 1'b0;
    logic [31:0] pk_a = '0, pk_d = '0;
    logic        err_en = 1'b0;
    logic [31:0] err_addr = '0;
    int          acc = 0;

    initial begin
        mem_ack_i   = 1'b0;
        mem_err_i   = 1'b0;
        mem_rdata_i = '0;
    end

    always @(posedge clk) begin
        mem_ack_i <= 1'b0;
        mem_err_i <= 1'b0;
        if (pk_en) mem[pk_a[9:2]] <= pk_d;
        if (mem_req_o && !mem_ack_i) begin
            mem_ack_i   <= 1'b1;
            acc         <= acc + 1;
            mem_rdata_i <= mem[mem_addr_o[9:2]];
            if (err_en && mem_addr_o == err_addr) mem_err_i <= 1'b1;
            else if (mem_we_o) mem[mem_addr_o[9:2]] <= mem_wdata_o;
        end
    end

    // card side
    logic [31:0] rd_base = 32'h5000_0000;
    logic [31:0] rd_idx = '0;
    assign cw_ready_i = 1'b1;
    assign cr_valid_i = 1'b1;
    assign cr_data_i  = rd_base + rd_idx;
    always @(posedge clk) if (cr_valid_i && cr_ready_o) rd_idx <= rd_idx + 1;

    // scoreboard
    int          n_chk = 0, n_fail = 0, done_cnt = 0;
    logic [31:0] exp_q[$];
    string       cur_req = "R4";

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (done_o) done_cnt++;
        if (cw_valid_o && cw_ready_i) begin
            if (exp_q.size() == 0) chk(cur_req, cw_data_o, 32'hxxxx_xxxx);
            else chk(cur_req, cw_data_o, exp_q.pop_front());
        end
    end

    task automatic push_seq(input logic [31:0] first, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(first + i);
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        pk_en = 1'b1; pk_a = a; pk_d = d;
        @(negedge clk);
        pk_en = 1'b0;
    endtask

    task automatic put_desc(input logic [31:0] at, input logic [31:0] st,
                            input logic [31:0] sz, input logic [31:0] bf,
                            input logic [31:0] nx);
        poke(at, st); poke(at + 4, sz); poke(at + 8, bf); poke(at + 12, nx);
    endtask

    logic [31:0] raw_c, dma_c;

    task automatic run(input logic wr, input logic [31:0] cnt, input logic [31:0] base,
                       input string req);
        bit got;
        is_write_i = wr; byte_count_i = cnt; desc_base_i = base;
        block_size_i = 32'd512; dma_en_i = 1'b1;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        got = 0;
        for (int i = 0; i < 3000 && !got; i++) begin
            if (done_o) begin
                got = 1; raw_c = dma_set_o; raw_c = raw_set_o; dma_c = dma_set_o;
            end else @(negedge clk);
        end
        chk({req, " done"}, 32'(got), 32'd1);
        @(negedge clk);
        chk({req, " queue drained"}, 32'(exp_q.size()), 32'd0);
        exp_q.delete();
    endtask

    task automatic try_reject(input logic en, input logic wr, input logic [31:0] cnt,
                              input logic [31:0] bs, input logic rdy);
        int a0, d0;
        a0 = acc; d0 = done_cnt;
        dma_en_i = en; is_write_i = wr; byte_count_i = cnt; block_size_i = bs;
        card_rdy_i = rdy; desc_base_i = 32'h0;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        repeat (10) @(negedge clk);
        chk("R7 busy", 32'(busy_o), 32'd0);
        chk("R7 accesses", 32'(acc - a0), 32'd0);
        chk("R7 done", 32'(done_cnt - d0), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // reset state
        chk("reset busy", 32'(busy_o), 32'd0);
        chk("reset req", 32'(mem_req_o), 32'd0);
        chk("reset remain", remain_o, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 8; i++) poke(32'h200 + 4 * i, 32'hA000_0000 + i);
        put_desc(32'h0, 32'h8000_000C, 32'd16, 32'h200, 32'h0);

        // R7: refused starts
        try_reject(1'b1, 1'b1, 32'd0, 32'd512, 1'b1);
        try_reject(1'b1, 1'b1, 32'd16, 32'd0, 1'b1);
        try_reject(1'b0, 1'b1, 32'd16, 32'd512, 1'b1);
        try_reject(1'b1, 1'b0, 32'd16, 32'd512, 1'b0);

        // single write descriptor, last flag, exact count
        begin
            int a0;
            a0 = acc; cur_req = "R4";
            push_seq(32'hA000_0000, 4);
            run(1'b1, 32'd16, 32'h0, "R4");
            chk("R8 raw", raw_c, 32'h0001_0008);
            chk("R8 dma write", dma_c, 32'h0000_0101);
            chk("R5 writeback", mem[0], 32'h0000_000C);
            chk("R9 remain", remain_o, 32'd0);
            chk("R11 accesses", 32'(acc - a0), 32'd9);
        end

        // chain of two, count runs out in the second, unaligned buffer
        for (int i = 0; i < 4; i++) poke(32'h240 + 4 * i, 32'hB000_0000 + i);
        poke(32'h280, 32'hC000_0000); poke(32'h284, 32'hC000_0001);
        put_desc(32'h40, 32'h8000_0010, 32'd16, 32'h240, 32'h80);
        put_desc(32'h80, 32'h8000_0000, 32'd16, 32'h283, 32'hC0);
        poke(32'hC0, 32'h8000_0000);
        cur_req = "R3";
        push_seq(32'hB000_0000, 4);
        push_seq(32'hC000_0000, 2);
        run(1'b1, 32'd24, 32'h40, "R6");
        chk("R1 first writeback", mem[16], 32'h0000_0010);
        chk("R1 second writeback via next", mem[32], 32'h0000_0000);
        chk("R6 no third fetch", mem[48], 32'h8000_0000);
        chk("R9 remain", remain_o, 32'd0);

        // last flag ends the list with bytes left
        put_desc(32'h100, 32'h8000_0004, 32'd8, 32'h200, 32'h140);
        poke(32'h140, 32'h8000_0000);
        cur_req = "R6";
        push_seq(32'hA000_0000, 2);
        run(1'b1, 32'd64, 32'h100, "R6");
        chk("R6 remain", remain_o, 32'd56);
        chk("R6 next untouched", mem[80], 32'h8000_0000);

        // size zero and oversized both clamp
        put_desc(32'h100, 32'h8000_0004, 32'd0, 32'h200, 32'h0);
        cur_req = "R2";
        push_seq(32'hA000_0000, 8);
        run(1'b1, 32'd100, 32'h100, "R2");
        chk("R2 zero size remain", remain_o, 32'd68);
        put_desc(32'h100, 32'h8000_0004, 32'd200, 32'h200, 32'h0);
        push_seq(32'hA000_0000, 8);
        run(1'b1, 32'd40, 32'h100, "R2");
        chk("R2 oversize remain", remain_o, 32'd8);

        // read direction
        begin
            logic [31:0] base0;
            card_rdy_i = 1'b1;
            put_desc(32'h180, 32'h8000_000C, 32'd12, 32'h300, 32'h0);
            base0 = rd_base + rd_idx;
            run(1'b0, 32'd12, 32'h180, "R4");
            chk("R4 read word0", mem[192], base0);
            chk("R4 read word1", mem[193], base0 + 1);
            chk("R4 read word2", mem[194], base0 + 2);
            chk("R8 dma read", dma_c, 32'h0000_0102);
            chk("R5 read writeback", mem[96], 32'h0000_000C);
        end

        // bus error mid-buffer
        put_desc(32'h1C0, 32'h8000_0010, 32'd16, 32'h200, 32'h40);
        poke(32'h40, 32'h8000_0000);
        err_addr = 32'h208; err_en = 1'b1;
        cur_req = "R10";
        push_seq(32'hA000_0000, 2);
        run(1'b1, 32'd32, 32'h1C0, "R10");
        err_en = 1'b0;
        chk("R10 error writeback", mem[112], 32'h4000_0010);
        chk("R10 chain stopped", mem[16], 32'h8000_0000);
        chk("R10 remain kept", remain_o, 32'd32);
        chk("R10 completion", raw_c, 32'h0001_0008);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule